// File: doc/BRIEF.md
# Local-Bus to PCI Window Translator

This block converts accesses from a 32-bit local bus master into single requests on a PCI-style initiator port. A fixed one-gigabyte aperture is decoded from the top two local address bits. Every access that falls inside it becomes exactly one PCI request. The low thirty address bits pass straight through. The two upper PCI address bits are taken from a field of a control register, so software chooses which quarter of PCI memory space the aperture reaches.

A single space-select bit in that control register switches the whole aperture between memory cycles and configuration cycles. In configuration mode, software places a one-hot device-select bit at address bit (13 + device), the function number in bits 10:8 and the dword register offset in bits 7:2. Only the bottom megabyte of the aperture is usable in this mode. The same control register also sets the drive of the PCI reset pin, the bus grant policy and a global cache-disable. A second register describes an uncached window. Each request is tagged when it falls inside that window or when caching is turned off.

Only one request is in flight at a time. The local master holds its request until it sees a one-cycle acknowledge. The far side ends each request with either done or a master abort. A master abort, or a configuration access the block rejects itself, produces a one-cycle abort event for the interrupt logic, and a read that aborts returns all ones.

Top module: `pci_window_xlate`

## Requirements
- R1: A local request whose address bits 31:30 equal 2'b10 (0x80000000 to 0xBFFFFFFF) issues exactly one PCI request. Any other address issues none and is acknowledged one cycle after it is sampled, with read data zero and no abort event.
- R2: The PCI request address is {ctrl[3:2], local address[29:0]}, where ctrl is the control register.
- R3: ctrl[1] selects the cycle type. The request carries pq_cfg = ctrl[1]: 0 means memory, 1 means configuration.
- R4: In configuration mode, an access whose address bits 29:20 are not all zero, or whose bits 1:0 are not zero, issues no PCI request. It is acknowledged one cycle after sampling with abort_evt high, and read data all ones for a read or zero for a write.
- R5: ctrl[5:4] drives the reset pin: 0 and 3 leave it undriven (rst_oe=0), 1 drives it low (rst_oe=1, rst_val=0), and 2 drives it high (rst_oe=1, rst_val=1).
- R6: grant_policy equals ctrl[7:6]. A request carries pq_nocache=1 when ctrl[12] is set or when its address hits the uncached window.
- R7: The uncached-window register holds a size code S in bits 4:0, an enable in bit 5 and a base in bits 31:30. When enabled, an address hits when every bit at position S and above equals the same bit of {base, 30'b0}.
- R8: A master abort (pr_abort) ends the request. lb_ack and abort_evt are high together for exactly one cycle, and a read returns 0xFFFFFFFF.
- R9: A request ended by pr_done is acknowledged in the following cycle. A read returns pr_rdata and a write returns zero, with no abort event.
- R10: pq_valid stays high with stable request fields until pr_done or pr_abort. lb_ack is never high while pq_valid is high.
- R11: pq_we, pq_be and pq_wdata carry the local write flag, byte enables and write data unchanged.
- R12: Register reads return the stored value with only writable bits kept: ctrl bits 1 to 7 and 12 (mask 0x000010FE), uncached bits 0 to 5 and 30 to 31 (mask 0xC000003F). rg_sel=0 selects ctrl and rg_sel=1 selects the uncached register. Both reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lb_req | input | 1 | Local request, held until lb_ack |
| lb_we | input | 1 | Local write flag |
| lb_addr | input | 32 | Local byte address |
| lb_be | input | 4 | Local byte enables |
| lb_wdata | input | 32 | Local write data |
| lb_ack | output | 1 | One-cycle completion |
| lb_rdata | output | 32 | Read data, valid with lb_ack |
| rg_wr | input | 1 | Register write strobe |
| rg_sel | input | 1 | Register select: 0 ctrl, 1 uncached window |
| rg_wdata | input | 32 | Register write data |
| rg_rdata | output | 32 | Selected register contents |
| pq_valid | output | 1 | PCI request pending |
| pq_cfg | output | 1 | 1 configuration cycle, 0 memory cycle |
| pq_we | output | 1 | PCI write flag |
| pq_addr | output | 32 | PCI address |
| pq_be | output | 4 | PCI byte enables |
| pq_wdata | output | 32 | PCI write data |
| pq_nocache | output | 1 | Request is uncached |
| pr_done | input | 1 | Far side completed the request |
| pr_abort | input | 1 | Far side master abort |
| pr_rdata | input | 32 | Read data with pr_done |
| abort_evt | output | 1 | One-cycle abort event |
| rst_oe | output | 1 | Reset pin output enable |
| rst_val | output | 1 | Reset pin driven level |
| grant_policy | output | 2 | Bus grant policy code |

## Verification
The hardest situation to reach is an uncached-window hit near a size boundary, while configuration mode, a shifted upper-address field and a delayed or aborted response are all in play at once. Every one of those settings has to be in the registers before the access starts. The stimulus therefore rewrites both registers with random values every few accesses. It draws window sizes across the full code range and addresses both inside and outside the aperture. In configuration mode it builds one-hot device addresses, and it holds each response back for a random number of cycles. Directed cases cover the aperture edges, the last valid configuration dword, the first address past the configuration span, and an unaligned configuration access.

// File: rtl/pwx_pkg.sv
package pwx_pkg;
   typedef enum logic [1:0] {
      PW_IDLE = 2'd0,
      PW_WAIT = 2'd1,
      PW_DONE = 2'd2
   } pw_state_e;

   localparam logic [31:0] CTRL_WMASK = 32'h0000_10FE;
   localparam logic [31:0] UNC_WMASK  = 32'hC000_003F;

   localparam int CTRL_CFG_BIT   = 1;
   localparam int CTRL_HI_LSB    = 2;
   localparam int CTRL_RST_LSB   = 4;
   localparam int CTRL_GNT_LSB   = 6;
   localparam int CTRL_NOCACHE   = 12;
   localparam int UNC_SIZE_LSB   = 0;
   localparam int UNC_EN_BIT     = 5;
   localparam int UNC_BASE_LSB   = 30;
endpackage

// File: rtl/pwx_regs.sv
module pwx_regs
   import pwx_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic          sel,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          cfg_sel,
   output logic [1:0]    hi_sel,
   output logic [1:0]    rst_mode,
   output logic [1:0]    grant,
   output logic          cache_off,
   output logic [4:0]    unc_size,
   output logic          unc_en,
   output logic [1:0]    unc_base
);
   logic [DW-1:0] ctrl_q;
   logic [DW-1:0] unc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         unc_q  <= '0;
      end else if (wr) begin
         if (sel) unc_q  <= wdata & UNC_WMASK;
         else     ctrl_q <= wdata & CTRL_WMASK;
      end
   end

   always_comb rdata = sel ? unc_q : ctrl_q;

   assign cfg_sel   = ctrl_q[CTRL_CFG_BIT];
   assign hi_sel    = ctrl_q[CTRL_HI_LSB +: 2];
   assign rst_mode  = ctrl_q[CTRL_RST_LSB +: 2];
   assign grant     = ctrl_q[CTRL_GNT_LSB +: 2];
   assign cache_off = ctrl_q[CTRL_NOCACHE];
   assign unc_size  = unc_q[UNC_SIZE_LSB +: 5];
   assign unc_en    = unc_q[UNC_EN_BIT];
   assign unc_base  = unc_q[UNC_BASE_LSB +: 2];
endmodule

// File: rtl/pwx_xlate.sv
module pwx_xlate #(
   parameter int          AW         = 32,
   parameter logic [1:0]  APER_TAG   = 2'b10,
   parameter int          CFG_SPAN_W = 20,
   parameter bit          ALIGN_CHK  = 1'b1
) (
   input  logic [AW-1:0] addr,
   input  logic          cfg_sel,
   input  logic [1:0]    hi_sel,
   input  logic [1:0]    rst_mode,
   input  logic          cache_off,
   input  logic [4:0]    unc_size,
   input  logic          unc_en,
   input  logic [1:0]    unc_base,
   output logic          in_ap,
   output logic          cfg_bad,
   output logic [AW-1:0] pci_addr,
   output logic          nocache,
   output logic          rst_oe,
   output logic          rst_val
);
   localparam int OFF_W = AW - 2;

   logic [AW-1:0] win_base;
   logic [AW-1:0] diff;
   logic          span_bad;
   logic          align_bad;

   assign in_ap    = (addr[AW-1:OFF_W] == APER_TAG);
   assign pci_addr = {hi_sel, addr[OFF_W-1:0]};
   assign win_base = {unc_base, {OFF_W{1'b0}}};

   for (genvar g = 0; g < AW; g++) begin : g_win
      assign diff[g] = (g >= int'(unc_size)) && (addr[g] ^ win_base[g]);
   end

   assign nocache  = cache_off | (unc_en & ~|diff);
   assign span_bad = |addr[OFF_W-1:CFG_SPAN_W];

   if (ALIGN_CHK) begin : g_align
      assign align_bad = |addr[1:0];
   end else begin : g_noalign
      assign align_bad = 1'b0;
   end

   assign cfg_bad = cfg_sel & (span_bad | align_bad);

   always_comb begin
      unique case (rst_mode)
         2'd1:    begin rst_oe = 1'b1; rst_val = 1'b0; end
         2'd2:    begin rst_oe = 1'b1; rst_val = 1'b1; end
         default: begin rst_oe = 1'b0; rst_val = 1'b0; end
      endcase
   end
endmodule

// File: rtl/pwx_seq.sv
module pwx_seq
   import pwx_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32,
   localparam int BW = DW / 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lb_req,
   input  logic          lb_we,
   input  logic [BW-1:0] lb_be,
   input  logic [DW-1:0] lb_wdata,
   input  logic          in_ap,
   input  logic          cfg_bad,
   input  logic          cfg_sel,
   input  logic [AW-1:0] pci_addr,
   input  logic          nocache,
   output logic          lb_ack,
   output logic [DW-1:0] lb_rdata,
   output logic          pq_valid,
   output logic          pq_cfg,
   output logic          pq_we,
   output logic [AW-1:0] pq_addr,
   output logic [BW-1:0] pq_be,
   output logic [DW-1:0] pq_wdata,
   output logic          pq_nocache,
   input  logic          pr_done,
   input  logic          pr_abort,
   input  logic [DW-1:0] pr_rdata,
   output logic          abort_evt
);
   pw_state_e st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= PW_IDLE;
         lb_ack     <= 1'b0;
         lb_rdata   <= '0;
         pq_valid   <= 1'b0;
         pq_cfg     <= 1'b0;
         pq_we      <= 1'b0;
         pq_addr    <= '0;
         pq_be      <= '0;
         pq_wdata   <= '0;
         pq_nocache <= 1'b0;
         abort_evt  <= 1'b0;
      end else begin
         lb_ack    <= 1'b0;
         abort_evt <= 1'b0;
         unique case (st)
            PW_IDLE: begin
               if (lb_req) begin
                  if (!in_ap) begin
                     st       <= PW_DONE;
                     lb_ack   <= 1'b1;
                     lb_rdata <= '0;
                  end else if (cfg_bad) begin
                     st        <= PW_DONE;
                     lb_ack    <= 1'b1;
                     abort_evt <= 1'b1;
                     lb_rdata  <= lb_we ? '0 : '1;
                  end else begin
                     st         <= PW_WAIT;
                     pq_valid   <= 1'b1;
                     pq_cfg     <= cfg_sel;
                     pq_we      <= lb_we;
                     pq_addr    <= pci_addr;
                     pq_be      <= lb_be;
                     pq_wdata   <= lb_wdata;
                     pq_nocache <= nocache;
                  end
               end
            end
            PW_WAIT: begin
               if (pr_abort) begin
                  st        <= PW_DONE;
                  pq_valid  <= 1'b0;
                  lb_ack    <= 1'b1;
                  abort_evt <= 1'b1;
                  lb_rdata  <= pq_we ? '0 : '1;
               end else if (pr_done) begin
                  st       <= PW_DONE;
                  pq_valid <= 1'b0;
                  lb_ack   <= 1'b1;
                  lb_rdata <= pq_we ? '0 : pr_rdata;
               end
            end
            default: st <= PW_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pci_window_xlate.sv
module pci_window_xlate #(
   parameter int          AW         = 32,
   parameter int          DW         = 32,
   parameter logic [1:0]  APER_TAG   = 2'b10,
   parameter int          CFG_SPAN_W = 20,
   parameter bit          ALIGN_CHK  = 1'b1,
   localparam int         BW         = DW / 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lb_req,
   input  logic          lb_we,
   input  logic [AW-1:0] lb_addr,
   input  logic [BW-1:0] lb_be,
   input  logic [DW-1:0] lb_wdata,
   output logic          lb_ack,
   output logic [DW-1:0] lb_rdata,
   input  logic          rg_wr,
   input  logic          rg_sel,
   input  logic [DW-1:0] rg_wdata,
   output logic [DW-1:0] rg_rdata,
   output logic          pq_valid,
   output logic          pq_cfg,
   output logic          pq_we,
   output logic [AW-1:0] pq_addr,
   output logic [BW-1:0] pq_be,
   output logic [DW-1:0] pq_wdata,
   output logic          pq_nocache,
   input  logic          pr_done,
   input  logic          pr_abort,
   input  logic [DW-1:0] pr_rdata,
   output logic          abort_evt,
   output logic          rst_oe,
   output logic          rst_val,
   output logic [1:0]    grant_policy
);
   if (AW != 32) begin : g_aw_chk
      $error("pci_window_xlate: AW must be 32");
   end
   if (DW != 32) begin : g_dw_chk
      $error("pci_window_xlate: DW must be 32");
   end
   if (CFG_SPAN_W < 3 || CFG_SPAN_W > AW - 3) begin : g_span_chk
      $error("pci_window_xlate: CFG_SPAN_W out of range");
   end

   logic          cfg_sel;
   logic [1:0]    hi_sel;
   logic [1:0]    rst_mode;
   logic          cache_off;
   logic [4:0]    unc_size;
   logic          unc_en;
   logic [1:0]    unc_base;
   logic          in_ap;
   logic          cfg_bad;
   logic [AW-1:0] pci_addr;
   logic          nocache;

   pwx_regs #(.DW(DW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (rg_wr),
      .sel       (rg_sel),
      .wdata     (rg_wdata),
      .rdata     (rg_rdata),
      .cfg_sel   (cfg_sel),
      .hi_sel    (hi_sel),
      .rst_mode  (rst_mode),
      .grant     (grant_policy),
      .cache_off (cache_off),
      .unc_size  (unc_size),
      .unc_en    (unc_en),
      .unc_base  (unc_base)
   );

   pwx_xlate #(
      .AW(AW), .APER_TAG(APER_TAG), .CFG_SPAN_W(CFG_SPAN_W), .ALIGN_CHK(ALIGN_CHK)
   ) u_xlate (
      .addr      (lb_addr),
      .cfg_sel   (cfg_sel),
      .hi_sel    (hi_sel),
      .rst_mode  (rst_mode),
      .cache_off (cache_off),
      .unc_size  (unc_size),
      .unc_en    (unc_en),
      .unc_base  (unc_base),
      .in_ap     (in_ap),
      .cfg_bad   (cfg_bad),
      .pci_addr  (pci_addr),
      .nocache   (nocache),
      .rst_oe    (rst_oe),
      .rst_val   (rst_val)
   );

   pwx_seq #(.AW(AW), .DW(DW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .lb_req     (lb_req),
      .lb_we      (lb_we),
      .lb_be      (lb_be),
      .lb_wdata   (lb_wdata),
      .in_ap      (in_ap),
      .cfg_bad    (cfg_bad),
      .cfg_sel    (cfg_sel),
      .pci_addr   (pci_addr),
      .nocache    (nocache),
      .lb_ack     (lb_ack),
      .lb_rdata   (lb_rdata),
      .pq_valid   (pq_valid),
      .pq_cfg     (pq_cfg),
      .pq_we      (pq_we),
      .pq_addr    (pq_addr),
      .pq_be      (pq_be),
      .pq_wdata   (pq_wdata),
      .pq_nocache (pq_nocache),
      .pr_done    (pr_done),
      .pr_abort   (pr_abort),
      .pr_rdata   (pr_rdata),
      .abort_evt  (abort_evt)
   );
endmodule

// File: rtl/pwx_checker.sv
module pwx_checker #(
   parameter int         AW       = 32,
   parameter logic [1:0] APER_TAG = 2'b10
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] lb_addr,
   input logic          lb_ack,
   input logic          pq_valid,
   input logic          pq_cfg,
   input logic [AW-1:0] pq_addr,
   input logic          pr_done,
   input logic          pr_abort,
   input logic          abort_evt,
   input logic          rst_oe,
   input logic          rst_val
);
   assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pq_valid && !pr_done && !pr_abort) |=> (pq_valid && $stable(pq_addr) && $stable(pq_cfg)));

   assert_ack_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pq_valid |-> !lb_ack);

   assert_abort_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      abort_evt |-> lb_ack);

   assert_abort_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      abort_evt |=> !abort_evt);

   assert_aperture_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pq_valid) |-> ($past(lb_addr[AW-1:AW-2]) == APER_TAG));

   assert_low_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pq_valid) |-> (pq_addr[AW-3:0] == $past(lb_addr[AW-3:0])));

   assert_rst_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rst_val |-> rst_oe);
endmodule

bind pci_window_xlate pwx_checker #(.AW(AW), .APER_TAG(APER_TAG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lb_addr   (lb_addr),
   .lb_ack    (lb_ack),
   .pq_valid  (pq_valid),
   .pq_cfg    (pq_cfg),
   .pq_addr   (pq_addr),
   .pr_done   (pr_done),
   .pr_abort  (pr_abort),
   .abort_evt (abort_evt),
   .rst_oe    (rst_oe),
   .rst_val   (rst_val)
);

// File: tb/sim_pci_window_xlate.sv
module sim_pci_window_xlate;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lb_req = 1'b0, lb_we = 1'b0;
   logic [31:0] lb_addr = '0, lb_wdata = '0;
   logic [3:0]  lb_be = '0;
   logic        lb_ack;
   logic [31:0] lb_rdata;
   logic        rg_wr = 1'b0, rg_sel = 1'b0;
   logic [31:0] rg_wdata = '0, rg_rdata;
   logic        pq_valid, pq_cfg, pq_we, pq_nocache;
   logic [31:0] pq_addr, pq_wdata;
   logic [3:0]  pq_be;
   logic        pr_done = 1'b0, pr_abort = 1'b0;
   logic [31:0] pr_rdata = '0;
   logic        abort_evt, rst_oe, rst_val;
   logic [1:0]  grant_policy;

   int checks = 0;
   int errors = 0;
   logic [31:0] m_ctrl = '0, m_unc = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pci_window_xlate u0 (
      .clk(clk), .rst_n(rst_n),
      .lb_req(lb_req), .lb_we(lb_we), .lb_addr(lb_addr), .lb_be(lb_be),
      .lb_wdata(lb_wdata), .lb_ack(lb_ack), .lb_rdata(lb_rdata),
      .rg_wr(rg_wr), .rg_sel(rg_sel), .rg_wdata(rg_wdata), .rg_rdata(rg_rdata),
      .pq_valid(pq_valid), .pq_cfg(pq_cfg), .pq_we(pq_we), .pq_addr(pq_addr),
      .pq_be(pq_be), .pq_wdata(pq_wdata), .pq_nocache(pq_nocache),
      .pr_done(pr_done), .pr_abort(pr_abort), .pr_rdata(pr_rdata),
      .abort_evt(abort_evt), .rst_oe(rst_oe), .rst_val(rst_val),
      .grant_policy(grant_policy)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic in_aperture(input logic [31:0] a);
      return a[31:30] == 2'b10;
   endfunction

   function automatic logic cfg_reject(input logic [31:0] a, input logic [31:0] c);
      return c[1] && (a[29:20] != 0 || a[1:0] != 0);
   endfunction

   function automatic logic win_hit(input logic [31:0] a, input logic [31:0] u);
      logic [63:0] keep;
      logic [31:0] base;
      keep = ~((64'd1 << u[4:0]) - 64'd1);
      base = {u[31:30], 30'b0};
      return u[5] && (((a ^ base) & keep[31:0]) == 0);
   endfunction

   task automatic reg_write(input logic sel, input logic [31:0] d);
      @(negedge clk);
      rg_wr = 1'b1; rg_sel = sel; rg_wdata = d;
      @(negedge clk);
      rg_wr = 1'b0;
      if (sel) m_unc = d & 32'hC000_003F;
      else     m_ctrl = d & 32'h0000_10FE;
      check("R12 readback", rg_rdata, sel ? m_unc : m_ctrl);
   endtask

   task automatic access(input logic [31:0] a, input logic we, input logic [3:0] be,
                         input logic [31:0] wd, input logic abrt, input int dly,
                         input logic [31:0] rd);
      logic expect_req, bad, got_req;
      logic [31:0] exp_rd;
      logic exp_ab;
      int n;
      expect_req = in_aperture(a) && !cfg_reject(a, m_ctrl);
      bad = in_aperture(a) && cfg_reject(a, m_ctrl);
      got_req = 1'b0;
      @(negedge clk);
      lb_req = 1'b1; lb_we = we; lb_addr = a; lb_be = be; lb_wdata = wd;
      @(negedge clk);
      if (pq_valid) begin
         got_req = 1'b1;
         check("R2 pq_addr", pq_addr, {m_ctrl[3:2], a[29:0]});
         check("R3 pq_cfg", {31'b0, pq_cfg}, {31'b0, m_ctrl[1]});
         check("R11 pq_we/be", {27'b0, pq_we, pq_be}, {27'b0, we, be});
         if (we) check("R11 pq_wdata", pq_wdata, wd);
         check("R6 R7 pq_nocache", {31'b0, pq_nocache},
               {31'b0, m_ctrl[12] | win_hit(a, m_unc)});
         for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            check("R10 held", {30'b0, pq_valid, lb_ack}, 32'd2);
         end
         pr_done = !abrt; pr_abort = abrt; pr_rdata = rd;
         @(negedge clk);
         pr_done = 1'b0; pr_abort = 1'b0;
      end
      check("R1 request issued", {31'b0, got_req}, {31'b0, expect_req});
      n = 0;
      while (!lb_ack && n < 20) begin
         @(negedge clk);
         n++;
      end
      if (!expect_req) exp_rd = bad ? (we ? 32'h0 : 32'hFFFF_FFFF) : 32'h0;
      else if (abrt)   exp_rd = we ? 32'h0 : 32'hFFFF_FFFF;
      else             exp_rd = we ? 32'h0 : rd;
      exp_ab = bad || (expect_req && abrt);
      check("R1 R9 ack timing", n, 0);
      check(bad ? "R4 reject data" : (abrt ? "R8 abort data" : "R9 data"), lb_rdata, exp_rd);
      check(bad ? "R4 abort evt" : "R8 abort evt", {31'b0, abort_evt}, {31'b0, exp_ab});
      lb_req = 1'b0;
      @(negedge clk);
      check("R8 ack pulse", {30'b0, lb_ack, abort_evt}, 32'd0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] a;
      int unsigned seed;
      seed = $urandom(32'h5EED_0042);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12 reset ctrl", rg_rdata, 32'h0);
      check("R10 reset pq_valid", {31'b0, pq_valid}, 32'h0);
      check("R5 reset drive", {30'b0, rst_oe, rst_val}, 32'h0);
      check("R6 reset grant", {30'b0, grant_policy}, 32'h0);

      for (int m = 0; m < 4; m++) begin
         reg_write(1'b0, 32'(m) << 4);
         check("R5 rst drive", {30'b0, rst_oe, rst_val},
               (m == 1) ? 32'd2 : (m == 2) ? 32'd3 : 32'd0);
      end
      reg_write(1'b0, 32'hFFFF_FFFF);
      check("R6 grant", {30'b0, grant_policy}, 32'd3);
      reg_write(1'b1, 32'hFFFF_FFFF);
      reg_write(1'b0, 32'h0000_0008);
      reg_write(1'b1, 32'h0);

      access(32'h7FFF_FFFC, 1'b0, 4'hF, 0, 1'b0, 0, 32'h1234_5678);
      access(32'h8000_0000, 1'b0, 4'hF, 0, 1'b0, 2, 32'hCAFE_0001);
      access(32'hBFFF_FFFC, 1'b1, 4'h3, 32'hA5A5_5A5A, 1'b0, 0, 0);
      access(32'hC000_0000, 1'b0, 4'hF, 0, 1'b0, 0, 32'h1);
      access(32'h8000_1000, 1'b0, 4'hF, 0, 1'b1, 1, 32'h5555_5555);
      reg_write(1'b1, 32'h8000_003E);
      access(32'h8000_0040, 1'b0, 4'hF, 0, 1'b0, 0, 32'h77);
      reg_write(1'b0, 32'h0000_0002);
      access(32'h800F_FFFC, 1'b0, 4'hF, 0, 1'b0, 0, 32'hBEEF);
      access(32'h8010_0000, 1'b0, 4'hF, 0, 1'b0, 0, 32'h0);
      access(32'h8000_2002, 1'b1, 4'h1, 32'h9, 1'b0, 0, 32'h0);
      access(32'h8001_0308, 1'b0, 4'hF, 0, 1'b1, 0, 32'h0);

      for (int i = 0; i < 160; i++) begin
         if (i % 8 == 0) begin
            reg_write(1'b0, $urandom());
            reg_write(1'b1, $urandom());
         end
         if (m_ctrl[1] && ($urandom() % 4 != 0))
            a = 32'h8000_0000 | (32'd1 << (13 + $urandom() % 7)) |
                (($urandom() % 8) << 8) | (($urandom() % 64) << 2);
         else if ($urandom() % 4 != 0)
            a = {2'b10, 30'($urandom())};
         else
            a = $urandom();
         access(a, 1'($urandom()), 4'($urandom()), $urandom(),
                ($urandom() % 4) == 0, $urandom() % 4, $urandom());
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule